// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This unit sits on the CPU side of a maskable interrupt path. The interrupt is already accepted when it arrives here. On an acknowledge pulse the unit saves the processor context in one clock. The return PC goes into a saved-PC register, the current status word goes into a saved-status register, and the exception code goes into the low half of a cause register. The unit also produces a new status word, with interrupt-disable set and the exception-pending flag cleared, and a redirect to the handler address. That address is a fixed base plus sixteen times the vector index.

On a return strobe the unit redirects to the saved PC and hands back the saved status word. Restoring that status word can clear interrupt-disable again, so held-back requests can be taken. Handlers that allow nesting must keep the saved copies somewhere safe while they run. For that, a small system-register port lets software read and write all three saved registers.

All outputs are registered. A request sampled at clock edge k is visible on the outputs just after edge k.

Top module: `irq_ctx_seq`

## Requirements
- R1: While `rst` is high at a clock edge, every saved register clears to zero. `redirect`, `nxt_pc` and `sr_rdata` also clear to zero, and `nxt_psw` takes the value `RESET_PSW`, which defaults to 0x0000_0020.
- R2: On an edge where `ack` is high, the saved-PC register takes `cur_pc`.
- R3: On an edge where `ack` is high, the saved-status register takes `cur_psw`.
- R4: On an edge where `ack` is high, bits 15:0 of the cause register take `exc_code`, and bits 31:16 keep their old value.
- R5: After an entry, `nxt_psw` equals `cur_psw` with bit 5 (interrupt-disable) set to 1 and bit 6 (exception-pending) cleared to 0. All other bits pass through unchanged.
- R6: After an entry, `redirect` is 1 for that cycle and `nxt_pc` equals 0x0000_0080 + 16 × `vec_idx`.
- R7: On an edge where `reti` is high and `ack` is low, `redirect` goes to 1. `nxt_pc` then takes the saved-PC value and `nxt_psw` the saved-status value, both as they stood before that edge.
- R8: When `ack` and `reti` are high on the same edge, the entry is carried out and the return is ignored.
- R9: The system-register port selects with `sr_sel`: 0 is saved PC, 1 is saved status, 2 is cause, and 3 is no register. An edge with `sr_we` high writes `sr_wdata` to the selected register, and code 3 writes nothing. On every edge, `sr_rdata` takes the selected register's value as it stood before that edge, and code 3 reads zero.
- R10: When `ack` and `sr_we` are high on the same edge, the software write is dropped in full and the entry values are stored.
- R11: On an edge where neither `ack` nor `reti` is high, `redirect` goes to 0 and `nxt_pc` and `nxt_psw` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack | input | 1 | Interrupt accepted; perform the entry save |
| reti | input | 1 | Return-from-interrupt strobe |
| cur_pc | input | 32 | Return PC to be saved |
| cur_psw | input | 32 | Current status word |
| vec_idx | input | 5 | Accepted vector index |
| exc_code | input | 16 | Exception code for the cause register |
| sr_we | input | 1 | System-register write enable |
| sr_sel | input | 2 | System-register select |
| sr_wdata | input | 32 | System-register write data |
| sr_rdata | output | 32 | Registered system-register read data |
| redirect | output | 1 | Next PC and PSW valid this cycle |
| nxt_pc | output | 32 | PC to continue from |
| nxt_psw | output | 32 | Status word to install |

## Verification
Three pairs of functions can fall on the same edge. An entry can collide with a return, an entry with a software write to a saved register, and a return with a software write. The random stream raises `ack`, `reti` and `sr_we` on independent draws, so every pairing occurs many times, and directed cases force each pair once on purpose. A bench model decides each outcome from the rules alone. Entry overrides both the return and the write. A return reads the values from before the edge, not the ones being written. The read port shows every register each cycle, so a write that slipped past an entry shows up as a miscompare.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;

  // System-register select codes seen on the sr_sel port.
  typedef enum logic [1:0] {
    SR_EIPC  = 2'd0,
    SR_EIPSW = 2'd1,
    SR_CAUSE = 2'd2,
    SR_NONE  = 2'd3
  } sr_sel_e;

  // What the flow controller does on a given edge.
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_ENTER  = 2'd1,
    ACT_RETURN = 2'd2
  } flow_act_e;

endpackage

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
  parameter int          XLEN         = 32,
  parameter int          VEC_W        = 5,
  parameter int          STRIDE_LG    = 4,
  parameter logic [31:0] HANDLER_BASE = 32'h0000_0080
) (
  input  logic [VEC_W-1:0] vec_idx,
  output logic [XLEN-1:0]  handler_addr
);

  localparam int PAD_W = XLEN - VEC_W - STRIDE_LG;

  logic [XLEN-1:0] offset;

  // Vector index scaled by the slot stride (a shift, no multiplier).
  generate
    if (PAD_W > 0) begin : g_pad
      assign offset = {{PAD_W{1'b0}}, vec_idx, {STRIDE_LG{1'b0}}};
    end else begin : g_nopad
      assign offset = XLEN'({vec_idx, {STRIDE_LG{1'b0}}});
    end
  endgenerate

  assign handler_addr = HANDLER_BASE[XLEN-1:0] + offset;

endmodule

// File: rtl/irq_save_regs.sv
module irq_save_regs
  import irq_ctx_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ack,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] cur_psw,
  input  logic [CODE_W-1:0] exc_code,
  input  logic            sr_we,
  input  logic [1:0]      sr_sel,
  input  logic [XLEN-1:0] sr_wdata,
  output logic [XLEN-1:0] eipc_q,
  output logic [XLEN-1:0] eipsw_q,
  output logic [XLEN-1:0] cause_q,
  output logic [XLEN-1:0] sr_rdata
);

  sr_sel_e sel;
  logic    sw_wr;
  logic [XLEN-1:0] rd_mux;

  assign sel   = sr_sel_e'(sr_sel);
  // Entry owns the saved registers on its edge; a software write then loses.
  assign sw_wr = sr_we && !ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      eipc_q <= '0;
    end else if (ack) begin
      eipc_q <= cur_pc;
    end else if (sw_wr && sel == SR_EIPC) begin
      eipc_q <= sr_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eipsw_q <= '0;
    end else if (ack) begin
      eipsw_q <= cur_psw;
    end else if (sw_wr && sel == SR_EIPSW) begin
      eipsw_q <= sr_wdata;
    end
  end

  // Cause register: entry touches only the low code field.
  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
    end else if (ack) begin
      cause_q[CODE_W-1:0] <= exc_code;
    end else if (sw_wr && sel == SR_CAUSE) begin
      cause_q <= sr_wdata;
    end
  end

  always_comb begin
    case (sel)
      SR_EIPC:  rd_mux = eipc_q;
      SR_EIPSW: rd_mux = eipsw_q;
      SR_CAUSE: rd_mux = cause_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) sr_rdata <= '0;
    else     sr_rdata <= rd_mux;
  end

  p_eipc_save_r2: assert property (@(posedge clk) disable iff (rst)
    ack |=> eipc_q == $past(cur_pc));

  p_eipsw_save_r3: assert property (@(posedge clk) disable iff (rst)
    ack |=> eipsw_q == $past(cur_psw));

  p_cause_upper_r4: assert property (@(posedge clk) disable iff (rst)
    ack |=> cause_q[XLEN-1:CODE_W] == $past(cause_q[XLEN-1:CODE_W]));

  p_cause_code_r4: assert property (@(posedge clk) disable iff (rst)
    ack |=> cause_q[CODE_W-1:0] == $past(exc_code));

  p_none_write_r9: assert property (@(posedge clk) disable iff (rst)
    (!ack && sel == SR_NONE) |=> $stable(eipc_q) && $stable(eipsw_q) && $stable(cause_q));

  p_none_read_r9: assert property (@(posedge clk) disable iff (rst)
    (sel == SR_NONE) |=> sr_rdata == '0);

endmodule

// File: rtl/irq_flow_ctl.sv
module irq_flow_ctl
  import irq_ctx_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          ID_BIT    = 5,
  parameter int          EP_BIT    = 6,
  parameter logic [31:0] RESET_PSW = 32'h0000_0020
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ack,
  input  logic            reti,
  input  logic [XLEN-1:0] handler_addr,
  input  logic [XLEN-1:0] cur_psw,
  input  logic [XLEN-1:0] eipc_q,
  input  logic [XLEN-1:0] eipsw_q,
  output logic            redirect,
  output logic [XLEN-1:0] nxt_pc,
  output logic [XLEN-1:0] nxt_psw
);

  flow_act_e       act;
  logic [XLEN-1:0] entry_psw;

  // Entry has priority; a return on the same edge is dropped.
  always_comb begin
    if (ack)       act = ACT_ENTER;
    else if (reti) act = ACT_RETURN;
    else           act = ACT_HOLD;
  end

  always_comb begin
    entry_psw         = cur_psw;
    entry_psw[ID_BIT] = 1'b1;
    entry_psw[EP_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect <= 1'b0;
      nxt_pc   <= '0;
      nxt_psw  <= RESET_PSW[XLEN-1:0];
    end else begin
      case (act)
        ACT_ENTER: begin
          redirect <= 1'b1;
          nxt_pc   <= handler_addr;
          nxt_psw  <= entry_psw;
        end
        ACT_RETURN: begin
          redirect <= 1'b1;
          nxt_pc   <= eipc_q;
          nxt_psw  <= eipsw_q;
        end
        default: begin
          redirect <= 1'b0;
        end
      endcase
    end
  end

  p_entry_flags_r5: assert property (@(posedge clk) disable iff (rst)
    ack |=> nxt_psw[ID_BIT] && !nxt_psw[EP_BIT]);

  p_entry_target_r6: assert property (@(posedge clk) disable iff (rst)
    ack |=> redirect && nxt_pc == $past(handler_addr));

  p_return_r7: assert property (@(posedge clk) disable iff (rst)
    (reti && !ack) |=> redirect && nxt_pc == $past(eipc_q) && nxt_psw == $past(eipsw_q));

  p_entry_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (ack && reti) |=> nxt_pc == $past(handler_addr));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!ack && !reti) |=> !redirect && $stable(nxt_pc) && $stable(nxt_psw));

endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
  import irq_ctx_pkg::*;
#(
  parameter int          XLEN         = 32,
  parameter int          VEC_W        = 5,
  parameter int          CODE_W       = 16,
  parameter int          STRIDE_LG    = 4,
  parameter int          ID_BIT       = 5,
  parameter int          EP_BIT       = 6,
  parameter logic [31:0] HANDLER_BASE = 32'h0000_0080,
  parameter logic [31:0] RESET_PSW    = 32'h0000_0020
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack,
  input  logic              reti,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_psw,
  input  logic [VEC_W-1:0]  vec_idx,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              sr_we,
  input  logic [1:0]        sr_sel,
  input  logic [XLEN-1:0]   sr_wdata,
  output logic [XLEN-1:0]   sr_rdata,
  output logic              redirect,
  output logic [XLEN-1:0]   nxt_pc,
  output logic [XLEN-1:0]   nxt_psw
);

  logic [XLEN-1:0] handler_addr;
  logic [XLEN-1:0] eipc_q;
  logic [XLEN-1:0] eipsw_q;
  logic [XLEN-1:0] cause_q;

  irq_vec_addr #(
    .XLEN(XLEN), .VEC_W(VEC_W), .STRIDE_LG(STRIDE_LG), .HANDLER_BASE(HANDLER_BASE)
  ) u_vec (
    .vec_idx      (vec_idx),
    .handler_addr (handler_addr)
  );

  irq_save_regs #(
    .XLEN(XLEN), .CODE_W(CODE_W)
  ) u_save (
    .clk      (clk),
    .rst      (rst),
    .ack      (ack),
    .cur_pc   (cur_pc),
    .cur_psw  (cur_psw),
    .exc_code (exc_code),
    .sr_we    (sr_we),
    .sr_sel   (sr_sel),
    .sr_wdata (sr_wdata),
    .eipc_q   (eipc_q),
    .eipsw_q  (eipsw_q),
    .cause_q  (cause_q),
    .sr_rdata (sr_rdata)
  );

  irq_flow_ctl #(
    .XLEN(XLEN), .ID_BIT(ID_BIT), .EP_BIT(EP_BIT), .RESET_PSW(RESET_PSW)
  ) u_flow (
    .clk          (clk),
    .rst          (rst),
    .ack          (ack),
    .reti         (reti),
    .handler_addr (handler_addr),
    .cur_psw      (cur_psw),
    .eipc_q       (eipc_q),
    .eipsw_q      (eipsw_q),
    .redirect     (redirect),
    .nxt_pc       (nxt_pc),
    .nxt_psw      (nxt_psw)
  );

  // R10: a software write on an entry edge must not survive into the saved PC.
  p_entry_beats_write_r10: assert property (@(posedge clk) disable iff (rst)
    (ack && sr_we) |=> eipc_q == $past(cur_pc) && eipsw_q == $past(cur_psw));

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> !redirect && nxt_pc == '0 && eipc_q == '0 && cause_q == '0);

endmodule

// File: tb/irq_ctx_seq_bench.sv
`timescale 1ns/1ps
module irq_ctx_seq_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        ack, reti, sr_we;
  logic [31:0] cur_pc, cur_psw, sr_wdata;
  logic [4:0]  vec_idx;
  logic [15:0] exc_code;
  logic [1:0]  sr_sel;
  logic [31:0] sr_rdata, nxt_pc, nxt_psw;
  logic        redirect;

  int unsigned n_vec  = 0;
  int unsigned n_fail = 0;
  bit          done   = 1'b0;

  // Bench model of the architectural state.
  logic [31:0] m_eipc, m_eipsw, m_cause, m_pc, m_psw, m_rd;
  logic        m_red;

  always #2 clk = ~clk;

  irq_ctx_seq u_irq_ctx_seq (
    .clk(clk), .rst(rst), .ack(ack), .reti(reti), .cur_pc(cur_pc),
    .cur_psw(cur_psw), .vec_idx(vec_idx), .exc_code(exc_code),
    .sr_we(sr_we), .sr_sel(sr_sel), .sr_wdata(sr_wdata),
    .sr_rdata(sr_rdata), .redirect(redirect), .nxt_pc(nxt_pc), .nxt_psw(nxt_psw)
  );

  function automatic logic [31:0] f_handler(input logic [4:0] v);
    return 32'h0000_0080 + 32'(v) * 32'd16;
  endfunction

  function automatic logic [31:0] f_entry_psw(input logic [31:0] p);
    logic [31:0] r;
    r = p;
    r[5] = 1'b1;
    r[6] = 1'b0;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic a, input logic r, input logic we, input logic [1:0] sel,
                     input logic [31:0] pc, input logic [31:0] psw, input logic [31:0] wd,
                     input logic [4:0] v, input logic [15:0] code);
    string t_pc, t_psw, t_sv;
    @(negedge clk);
    ack = a; reti = r; sr_we = we; sr_sel = sel; cur_pc = pc; cur_psw = psw;
    sr_wdata = wd; vec_idx = v; exc_code = code;
    case (sel)
      2'd0: m_rd = m_eipc;
      2'd1: m_rd = m_eipsw;
      2'd2: m_rd = m_cause;
      default: m_rd = 32'h0;
    endcase
    t_pc  = (a && r) ? "R8" : a ? "R6" : r ? "R7" : "R11";
    t_psw = a ? "R5" : r ? "R7" : "R11";
    t_sv  = (a && we) ? "R10" : a ? "R2" : "R9";
    if (a) begin
      m_red = 1'b1; m_pc = f_handler(v); m_psw = f_entry_psw(psw);
    end else if (r) begin
      m_red = 1'b1; m_pc = m_eipc; m_psw = m_eipsw;
    end else begin
      m_red = 1'b0;
    end
    if (a) begin
      m_eipc = pc; m_eipsw = psw; m_cause[15:0] = code;
    end else if (we) begin
      case (sel)
        2'd0: m_eipc = wd;
        2'd1: m_eipsw = wd;
        2'd2: m_cause = wd;
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    chk({t_pc, " redirect"}, {31'h0, redirect}, {31'h0, m_red});
    chk({t_pc, " nxt_pc"}, nxt_pc, m_pc);
    chk({t_psw, " nxt_psw"}, nxt_psw, m_psw);
    chk("R9 sr_rdata", sr_rdata, m_rd);
  endtask

  // Reads a register back through the port; needs one extra cycle.
  task automatic peek(input string tag, input logic [1:0] sel, input logic [31:0] exp);
    cyc(1'b0, 1'b0, 1'b0, sel, 32'h0, 32'h0, 32'h0, 5'd0, 16'h0);
    chk(tag, sr_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R11 actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst = 1'b1; ack = 0; reti = 0; sr_we = 0; sr_sel = 2'd3;
    cur_pc = 0; cur_psw = 0; sr_wdata = 0; vec_idx = 0; exc_code = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 redirect", {31'h0, redirect}, 32'h0);
    chk("R1 nxt_pc", nxt_pc, 32'h0);
    chk("R1 nxt_psw", nxt_psw, 32'h0000_0020);
    chk("R1 sr_rdata", sr_rdata, 32'h0);
    m_eipc = 0; m_eipsw = 0; m_cause = 0; m_pc = 0; m_psw = 32'h20; m_red = 0; m_rd = 0;
    @(negedge clk);
    rst = 1'b0;

    // R1: saved registers read zero after reset
    peek("R1 eipc", 2'd0, 32'h0);
    peek("R1 cause", 2'd2, 32'h0);

    // R4: upper cause half survives an entry
    cyc(1'b0, 1'b0, 1'b1, 2'd2, 32'h0, 32'h0, 32'hABCD_0000, 5'd0, 16'h0);
    cyc(1'b1, 1'b0, 1'b0, 2'd3, 32'h0000_1234, 32'h0000_0040, 32'h0, 5'd31, 16'h1234);
    chk("R6 last vector", nxt_pc, 32'h0000_0270);
    chk("R5 ep cleared id set", nxt_psw, 32'h0000_0020);
    peek("R4 cause merge", 2'd2, 32'hABCD_1234);
    peek("R2 eipc", 2'd0, 32'h0000_1234);
    peek("R3 eipsw", 2'd1, 32'h0000_0040);

    // R8: entry and return together
    cyc(1'b1, 1'b1, 1'b0, 2'd3, 32'h0000_5000, 32'h0, 32'h0, 5'd0, 16'h0007);
    chk("R8 entry wins", nxt_pc, 32'h0000_0080);

    // R10: entry and software write together
    cyc(1'b1, 1'b0, 1'b1, 2'd0, 32'h0000_6000, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 5'd1, 16'h0008);
    peek("R10 write dropped", 2'd0, 32'h0000_6000);

    // R7: return restores saved PC/PSW; return with write in same edge reads old
    cyc(1'b0, 1'b1, 1'b1, 2'd0, 32'h0, 32'h0, 32'h0000_7777, 5'd0, 16'h0);
    chk("R7 return old pc", nxt_pc, 32'h0000_6000);
    chk("R7 return psw", nxt_psw, 32'hFFFF_FFFF);

    // R9: select 3 writes nothing and reads zero
    cyc(1'b0, 1'b0, 1'b1, 2'd3, 32'h0, 32'h0, 32'h1111_1111, 5'd0, 16'h0);
    peek("R9 none reads zero", 2'd3, 32'h0);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 3) == 0,
          2'($urandom), $urandom, $urandom, $urandom, 5'($urandom), 16'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule